// File: doc/BRIEF.md
# Relocatable On-Chip RAM Controller

A 2 KiB static RAM that sits on a 24-bit internal bus at a base address software can move. A configuration register holds the upper address bits of the base and a disable flag. A control register holds a halt bit and a supervisor-only bit. A bus access is claimed only when the array is enabled and not halted, emulation is off, the upper address bits match the base, and the privilege check passes. An unclaimed access gets no acknowledge, so an external responder can decode the same range.

Each bus cycle takes two clocks. The first clock is the one in which the request is sampled, and the acknowledge comes in the second. Byte accesses and even-address word accesses use one bus cycle. Long words and odd-address words are split into two word cycles that run back to back. The data on the bus is big-endian: the byte at the lower address is the more significant one.

A synchronous reset request lets an access in progress finish before the registers return to their reset state. A long word that is still in its first word keeps only that first word.

Top module: `ram_reloc_ctl`

## Requirements
- R1: After reset the base register reads 0x0001 and the control register reads 0x0000. Bit 0 of the base register is the disable flag, and the array claims no access while the flag is set.
- R2: A supervisor write to the base register (cfg_sel_i=1) loads bits [15:3] as address bits [23:11] of the base and clears the disable flag. Written bits [2:0] are ignored, and bits [2:1] read as zero.
- R3: An access is acknowledged only when all of these hold: the array is enabled, the halt bit is clear, emu_i is low, addr_i[23:11] equals the base, the privilege check passes, size_i is not 3, and a long access is at an even address. Any other access gets no acknowledge and leaves the array contents unchanged.
- R4: Control bit 0 (cfg_sel_i=0) set to 1 makes the array answer only accesses with super_i=1. When it is 0, both privilege levels are answered.
- R5: A byte access (size_i=0) or an even-address word access (size_i=1) asserts ack_o in the clock after the request is sampled. The byte at the even address maps to data bits [15:8] of a word, and a byte uses data bits [7:0] of the bus.
- R6: A long access (size_i=2, data bits [31:0], upper half at the lower address) and an odd-address word access each take two bus cycles, with ack_o in the fourth clock. The second word index wraps modulo the array depth.
- R7: A sync_rst_i pulse during a one-cycle access, or during the second word of a split access, lets the access complete with its acknowledge. The registers then return to their reset state.
- R8: A sync_rst_i pulse during the first word of a split access writes only that first word, gives no acknowledge, and returns the registers to their reset state.
- R9: Control bit 1 halts the array: accesses get no acknowledge and the stored data is kept. Clearing the bit restores access to the same data.
- R10: While emu_i is high, no bus access is acknowledged and the array is left untouched.
- R11: Register writes with cfg_super_i=0 are ignored, and register reads with cfg_super_i=0 return zero.
- R12: A sync_rst_i pulse while no access is in progress resets the registers at that edge and prevents a request sampled at the same edge from starting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| sync_rst_i | input | 1 | Synchronous reset request |
| emu_i | input | 1 | Emulation select; blocks bus access |
| req_i | input | 1 | Access request, held until acknowledge |
| addr_i | input | 24 | Byte address |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| wr_i | input | 1 | 1 write, 0 read |
| super_i | input | 1 | Supervisor privilege of the access |
| wdata_i | input | 32 | Write data, right-aligned by size |
| ack_o | output | 1 | Access acknowledge |
| rdata_o | output | 32 | Read data, valid with ack_o |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 control register, 1 base register |
| cfg_super_i | input | 1 | Supervisor privilege of the register access |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data |

## Verification
The bench builds the block with its default parameters, ADDR_W=24 and WORDS=1024. With these values the base field fills register bits [15:3] exactly, and the whole array can be filled and checked within the cycle limit. Split accesses that cross from the last word back to word 0 are therefore reachable with concrete addresses. Random traffic mixes sizes, privilege levels and in-range and out-of-range addresses, and occasionally flips the supervisor-only bit. The directed cases place the synchronous reset pulse in the capture clock, in the first word and in the second word of a split access.

// File: rtl/ram_reloc_pkg.sv
package ram_reloc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_B1   = 2'd1,  // second clock of first word
    ST_B2A  = 2'd2,  // first clock of second word
    ST_B2B  = 2'd3   // second clock of second word
  } seq_state_e;
endpackage

// File: rtl/ram_cfg_regs.sv
module ram_cfg_regs #(
  parameter int BASE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic              super_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic [BASE_W-1:0] base_o,
  output logic              dis_o,
  output logic              halt_o,
  output logic              sup_only_o
);
  localparam int BASE_LO = 16 - BASE_W;

  logic unused_wd;
  assign unused_wd = ^wdata_i[BASE_LO-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= '0;
      dis_o      <= 1'b1;
      halt_o     <= 1'b0;
      sup_only_o <= 1'b0;
    end else if (clr_i) begin
      base_o     <= '0;
      dis_o      <= 1'b1;
      halt_o     <= 1'b0;
      sup_only_o <= 1'b0;
    end else if (we_i && super_i) begin
      if (sel_i) begin
        base_o <= wdata_i[15:BASE_LO];
        dis_o  <= 1'b0;
      end else begin
        halt_o     <= wdata_i[1];
        sup_only_o <= wdata_i[0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (super_i) begin
      if (sel_i) rdata_o = {base_o, {(BASE_LO-1){1'b0}}, dis_o};
      else       rdata_o = {14'b0, halt_o, sup_only_o};
    end
  end
endmodule

// File: rtl/ram_decode.sv
module ram_decode
  import ram_reloc_pkg::*;
#(
  parameter int BASE_W = 13
) (
  input  logic [BASE_W-1:0] addr_hi_i,
  input  logic              odd_i,
  input  acc_size_e         size_i,
  input  logic              super_i,
  input  logic              emu_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              dis_i,
  input  logic              halt_i,
  input  logic              sup_only_i,
  output logic              hit_o
);
  logic avail, space_ok, size_ok;

  assign avail    = !dis_i && !halt_i && !emu_i;
  assign space_ok = !sup_only_i || super_i;
  assign size_ok  = (size_i != SZ_RSVD) && !((size_i == SZ_LONG) && odd_i);
  assign hit_o    = avail && space_ok && size_ok && (addr_hi_i == base_i);
endmodule

// File: rtl/ram_array.sv
module ram_array #(
  parameter int WORDS = 1024,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       we_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[idx_i] <= wdata_i[g*8 +: 8];
    end
    assign rdata_o[g*8 +: 8] = mem[idx_i];
  end
endmodule

// File: rtl/ram_seq.sv
module ram_seq
  import ram_reloc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             hit_i,
  input  logic             sync_rst_i,
  input  logic [IDX_W:0]   ofs_i,
  input  acc_size_e        size_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic [15:0]      arr_rdata_i,
  output logic [IDX_W-1:0] arr_idx_o,
  output logic [1:0]       arr_we_o,
  output logic [15:0]      arr_wdata_o,
  output logic             ack_o,
  output logic [31:0]      rdata_o,
  output logic             clr_o,
  output logic             idle_o
);
  seq_state_e       state_q, state_d;
  acc_size_e        size_q;
  logic [IDX_W-1:0] idx_q;
  logic             odd_q, wr_q, pend_q;
  logic [31:0]      wdata_q;
  logic [15:0]      hold_q;
  logic             start, split, rst_req;

  assign idle_o  = (state_q == ST_IDLE);
  assign start   = idle_o && req_i && hit_i && !sync_rst_i;
  assign split   = (size_q == SZ_LONG) || ((size_q == SZ_WORD) && odd_q);
  assign rst_req = pend_q || sync_rst_i;
  assign ack_o   = ((state_q == ST_B1) && !split) || (state_q == ST_B2B);
  assign clr_o   = (idle_o && sync_rst_i) ||
                   (((state_q == ST_B1) || (state_q == ST_B2B)) && rst_req);
  assign arr_idx_o = ((state_q == ST_B2A) || (state_q == ST_B2B)) ? idx_q + IDX_W'(1) : idx_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_B1;
      ST_B1:   state_d = (split && !rst_req) ? ST_B2A : ST_IDLE;
      ST_B2A:  state_d = ST_B2B;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      size_q  <= SZ_BYTE;
      idx_q   <= '0;
      odd_q   <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      hold_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= clr_o ? 1'b0 : (pend_q || (sync_rst_i && !idle_o));
      if (start) begin
        size_q  <= size_i;
        idx_q   <= ofs_i[IDX_W:1];
        odd_q   <= ofs_i[0];
        wr_q    <= wr_i;
        wdata_q <= wdata_i;
      end
      if (state_q == ST_B1) hold_q <= arr_rdata_i;
    end
  end

  // lane enables: bit 1 = even-address byte
  always_comb begin
    arr_we_o    = '0;
    arr_wdata_o = '0;
    if (wr_q && (state_q == ST_B1)) begin
      case (size_q)
        SZ_BYTE: begin
          arr_we_o    = odd_q ? 2'b01 : 2'b10;
          arr_wdata_o = {2{wdata_q[7:0]}};
        end
        SZ_WORD: begin
          arr_we_o    = odd_q ? 2'b01 : 2'b11;
          arr_wdata_o = odd_q ? {2{wdata_q[15:8]}} : wdata_q[15:0];
        end
        SZ_LONG: begin
          arr_we_o    = 2'b11;
          arr_wdata_o = wdata_q[31:16];
        end
        default: ;
      endcase
    end else if (wr_q && (state_q == ST_B2B)) begin
      if (size_q == SZ_LONG) begin
        arr_we_o    = 2'b11;
        arr_wdata_o = wdata_q[15:0];
      end else begin
        arr_we_o    = 2'b10;
        arr_wdata_o = {2{wdata_q[7:0]}};
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ack_o && !wr_q) begin
      case (size_q)
        SZ_BYTE: rdata_o = {24'b0, odd_q ? arr_rdata_i[7:0] : arr_rdata_i[15:8]};
        SZ_WORD: rdata_o = odd_q ? {16'b0, hold_q[7:0], arr_rdata_i[15:8]}
                                 : {16'b0, arr_rdata_i};
        SZ_LONG: rdata_o = {hold_q, arr_rdata_i};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ram_reloc_ctl.sv
module ram_reloc_ctl
  import ram_reloc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORDS  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_rst_i,
  input  logic              emu_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              wr_i,
  input  logic              super_i,
  input  logic [31:0]       wdata_i,
  output logic              ack_o,
  output logic [31:0]       rdata_o,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic              cfg_super_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_rdata_o
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int OFS_W  = IDX_W + 1;
  localparam int BASE_W = ADDR_W - OFS_W;

  acc_size_e        acc_size;
  logic [BASE_W-1:0] base_q;
  logic             ram_dis, ram_halt, ram_sup_only;
  logic             hit, regs_clr, seq_idle;
  logic [IDX_W-1:0] arr_idx;
  logic [1:0]       arr_we;
  logic [15:0]      arr_wdata, arr_rdata;

  assign acc_size = acc_size_e'(size_i);

  ram_cfg_regs #(.BASE_W(BASE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (regs_clr),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .super_i    (cfg_super_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .base_o     (base_q),
    .dis_o      (ram_dis),
    .halt_o     (ram_halt),
    .sup_only_o (ram_sup_only)
  );

  ram_decode #(.BASE_W(BASE_W)) u_dec (
    .addr_hi_i  (addr_i[ADDR_W-1:OFS_W]),
    .odd_i      (addr_i[0]),
    .size_i     (acc_size),
    .super_i    (super_i),
    .emu_i      (emu_i),
    .base_i     (base_q),
    .dis_i      (ram_dis),
    .halt_i     (ram_halt),
    .sup_only_i (ram_sup_only),
    .hit_o      (hit)
  );

  ram_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .hit_i       (hit),
    .sync_rst_i  (sync_rst_i),
    .ofs_i       (addr_i[OFS_W-1:0]),
    .size_i      (acc_size),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .arr_rdata_i (arr_rdata),
    .arr_idx_o   (arr_idx),
    .arr_we_o    (arr_we),
    .arr_wdata_o (arr_wdata),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .clr_o       (regs_clr),
    .idle_o      (seq_idle)
  );

  ram_array #(.WORDS(WORDS)) u_arr (
    .clk_i   (clk_i),
    .idx_i   (arr_idx),
    .we_i    (arr_we),
    .wdata_i (arr_wdata),
    .rdata_o (arr_rdata)
  );
endmodule

// File: rtl/ram_reloc_ctl_chk.sv
module ram_reloc_ctl_chk #(
  parameter int BASE_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_rst_i,
  input logic              emu_i,
  input logic              cfg_we_i,
  input logic              cfg_super_i,
  input logic              ack_o,
  input logic              seq_idle,
  input logic              ram_dis,
  input logic              ram_halt,
  input logic              regs_clr,
  input logic [BASE_W-1:0] base_q
);
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_idle && ram_dis) |=> seq_idle);  // R1
  AST_ACK_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);  // R5
  AST_ACK_ENDS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> seq_idle);  // R6
  AST_HALT_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_idle && ram_halt) |=> seq_idle);  // R9
  AST_EMU_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_idle && emu_i) |=> seq_idle);  // R10
  AST_USER_CFG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_super_i && !regs_clr) |=> ($stable(base_q) && $stable(ram_halt) && $stable(ram_dis)));  // R11
  AST_IDLE_SYNC_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_idle && sync_rst_i) |=> (ram_dis && seq_idle));  // R12
endmodule

bind ram_reloc_ctl ram_reloc_ctl_chk #(.BASE_W(BASE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_rst_i  (sync_rst_i),
  .emu_i       (emu_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_super_i (cfg_super_i),
  .ack_o       (ack_o),
  .seq_idle    (seq_idle),
  .ram_dis     (ram_dis),
  .ram_halt    (ram_halt),
  .regs_clr    (regs_clr),
  .base_q      (base_q)
);

// File: tb/ram_reloc_ctl_test.sv
`timescale 1ns/1ps
module ram_reloc_ctl_test;
  logic        clk = 1'b0;
  logic        rst_ni, sync_rst_i, emu_i, req_i, wr_i, super_i;
  logic [23:0] addr_i;
  logic [1:0]  size_i;
  logic [31:0] wdata_i, rdata_o;
  logic        ack_o;
  logic        cfg_we_i, cfg_sel_i, cfg_super_i;
  logic [15:0] cfg_wdata_i, cfg_rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  mem_m [2048];
  logic [12:0] base_m;
  bit          dis_m, halt_m, sup_m;

  always #10 clk = ~clk;

  ram_reloc_ctl uut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_rst_i(sync_rst_i), .emu_i(emu_i),
    .req_i(req_i), .addr_i(addr_i), .size_i(size_i), .wr_i(wr_i),
    .super_i(super_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_super_i(cfg_super_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [23:0] a, input logic [1:0] sz, input bit s);
    return !dis_m && !halt_m && !emu_i && (a[23:11] == base_m) && (!sup_m || s) &&
           (sz != 2'd3) && !((sz == 2'd2) && a[0]);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [23:0] a, input logic [1:0] sz);
    logic [10:0] o = a[10:0];
    case (sz)
      2'd0:    return {24'b0, mem_m[o]};
      2'd1:    return {16'b0, mem_m[o], mem_m[11'(o+1)]};
      default: return {mem_m[o], mem_m[11'(o+1)], mem_m[11'(o+2)], mem_m[11'(o+3)]};
    endcase
  endfunction

  task automatic model_wr(input logic [23:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input int nb);
    logic [10:0] o = a[10:0];
    case (sz)
      2'd0: mem_m[o] = d[7:0];
      2'd1: begin
        mem_m[o] = d[15:8];
        if (nb > 1) mem_m[11'(o+1)] = d[7:0];
      end
      default: begin
        mem_m[o] = d[31:24];
        mem_m[11'(o+1)] = d[23:16];
        if (nb > 2) begin
          mem_m[11'(o+2)] = d[15:8];
          mem_m[11'(o+3)] = d[7:0];
        end
      end
    endcase
  endtask

  task automatic model_reset();
    base_m = '0; dis_m = 1; halt_m = 0; sup_m = 0;
  endtask

  task automatic cfg_write(input bit sel, input logic [15:0] d, input bit s);
    cfg_sel_i = sel; cfg_wdata_i = d; cfg_super_i = s; cfg_we_i = 1;
    @(negedge clk);
    cfg_we_i = 0; cfg_super_i = 1;
    if (s) begin
      if (sel) begin base_m = d[15:3]; dis_m = 0; end
      else begin halt_m = d[1]; sup_m = d[0]; end
    end
  endtask

  task automatic cfg_read(input bit sel, input bit s, output logic [15:0] v);
    cfg_sel_i = sel; cfg_super_i = s;
    #1 v = cfg_rdata_o;
    cfg_super_i = 1;
  endtask

  task automatic run_acc(input logic [23:0] a, input logic [1:0] sz, input bit w,
                         input logic [31:0] d, input bit s, input int rst_at,
                         output bit got, output logic [31:0] rd, output int cnt);
    got = 0; rd = '0; cnt = 0;
    addr_i = a; size_i = sz; wr_i = w; wdata_i = d; super_i = s;
    req_i = 1; sync_rst_i = (rst_at == 0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      sync_rst_i = (k == rst_at);
      if (ack_o) begin got = 1; rd = rdata_o; cnt = k; req_i = 0; break; end
    end
    req_i = 0;
    @(negedge clk);
    sync_rst_i = 0;
  endtask

  task automatic do_acc(input logic [23:0] a, input logic [1:0] sz, input bit w,
                        input logic [31:0] d, input bit s, input int rst_at, input string tag);
    bit hit, split, exp_ack, got;
    logic [31:0] rd, er;
    int cnt;
    hit = exp_hit(a, sz, s);
    split = (sz == 2'd2) || ((sz == 2'd1) && a[0]);
    exp_ack = hit && (rst_at != 0) && !(split && rst_at == 1);
    er = exp_rd(a, sz);
    run_acc(a, sz, w, d, s, rst_at, got, rd, cnt);
    chk(got == exp_ack, tag, "ack", 32'(got), 32'(exp_ack));
    if (exp_ack && got) begin
      chk(cnt == (split ? 3 : 1), tag, "ack clock", 32'(cnt), split ? 32'd3 : 32'd1);
      if (!w) chk(rd == er, tag, "rdata", rd, er);
    end
    if (hit && rst_at != 0 && w) model_wr(a, sz, d, exp_ack ? 4 : (sz == 2'd2 ? 2 : 1));
    if (rst_at >= 0) model_reset();
  endtask

  task automatic chk_reg(input bit sel, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    cfg_read(sel, 1, v);
    chk(v == exp, tag, sel ? "base reg" : "ctrl reg", 32'(v), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] bb;
    logic [15:0] v;
    void'($urandom(32'h5EED_0042));
    rst_ni = 0; sync_rst_i = 0; emu_i = 0; req_i = 0; wr_i = 0; super_i = 0;
    addr_i = '0; size_i = '0; wdata_i = '0;
    cfg_we_i = 0; cfg_sel_i = 0; cfg_super_i = 1; cfg_wdata_i = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk_reg(1, 16'h0001, "R1");
    chk_reg(0, 16'h0000, "R1");
    do_acc(24'h000000, 2'd0, 0, 0, 1, -1, "R1");

    // R11 user register access
    cfg_write(1, 16'h1238, 0);
    chk_reg(1, 16'h0001, "R11");
    cfg_read(1, 0, v);
    chk(v == 16'h0000, "R11", "user read", 32'(v), 32'h0);

    // R2 base write
    cfg_write(1, 16'hABCF, 1);
    chk_reg(1, 16'hABC8, "R2");
    bb = {base_m, 11'h0};

    for (int j = 0; j < 512; j++) do_acc(bb + 24'(4*j), 2'd2, 1, $urandom, 1, -1, "R6");

    // R5 single-cycle accesses, lane order
    do_acc(bb + 24'h10, 2'd0, 1, 32'h5A, 1, -1, "R5");
    do_acc(bb + 24'h11, 2'd0, 1, 32'hC3, 1, -1, "R5");
    do_acc(bb + 24'h10, 2'd1, 0, 0, 1, -1, "R5");
    do_acc(bb + 24'h11, 2'd0, 0, 0, 0, -1, "R5");
    do_acc(bb + 24'h12, 2'd1, 1, 32'h1234, 0, -1, "R5");
    do_acc(bb + 24'h12, 2'd0, 0, 0, 1, -1, "R5");

    // R6 split accesses and wrap
    do_acc(bb + 24'h21, 2'd1, 1, 32'hBEEF, 1, -1, "R6");
    do_acc(bb + 24'h20, 2'd2, 0, 0, 1, -1, "R6");
    do_acc(bb + 24'h21, 2'd1, 0, 0, 1, -1, "R6");
    do_acc(bb + 24'h7FE, 2'd2, 1, 32'hA1B2C3D4, 1, -1, "R6");
    do_acc(bb + 24'h000, 2'd1, 0, 0, 1, -1, "R6");
    do_acc(bb + 24'h7FE, 2'd1, 0, 0, 1, -1, "R6");
    do_acc(bb + 24'h7FF, 2'd1, 1, 32'h9966, 1, -1, "R6");
    do_acc(bb + 24'h7FE, 2'd2, 0, 0, 1, -1, "R6");
    do_acc(bb + 24'h31, 2'd2, 1, 32'hFFFFFFFF, 1, -1, "R3");
    do_acc(bb + 24'h30, 2'd3, 1, 32'hFFFFFFFF, 1, -1, "R3");
    do_acc(bb + 24'h30, 2'd2, 0, 0, 1, -1, "R3");

    // R3 miss leaves array unchanged
    do_acc(bb ^ 24'h000800 | 24'h40, 2'd1, 1, 32'h0BAD, 1, -1, "R3");
    do_acc(bb | 24'h40, 2'd1, 0, 0, 1, -1, "R3");

    // R4 supervisor-only space
    cfg_write(0, 16'h0001, 1);
    chk_reg(0, 16'h0001, "R4");
    do_acc(bb + 24'h50, 2'd1, 0, 0, 0, -1, "R4");
    do_acc(bb + 24'h50, 2'd1, 1, 32'h7777, 0, -1, "R4");
    do_acc(bb + 24'h50, 2'd1, 0, 0, 1, -1, "R4");
    cfg_write(0, 16'h0000, 1);
    do_acc(bb + 24'h50, 2'd1, 0, 0, 0, -1, "R4");

    // R9 halt keeps data
    cfg_write(0, 16'h0002, 1);
    chk_reg(0, 16'h0002, "R9");
    do_acc(bb + 24'h40, 2'd1, 0, 0, 1, -1, "R9");
    do_acc(bb + 24'h40, 2'd1, 1, 32'hDEAD, 1, -1, "R9");
    cfg_write(0, 16'h0000, 1);
    do_acc(bb + 24'h40, 2'd1, 0, 0, 1, -1, "R9");

    // R10 emulation blocks access
    emu_i = 1;
    do_acc(bb + 24'h60, 2'd2, 1, 32'h01020304, 1, -1, "R10");
    do_acc(bb + 24'h60, 2'd2, 0, 0, 1, -1, "R10");
    emu_i = 0;
    do_acc(bb + 24'h60, 2'd2, 0, 0, 1, -1, "R10");

    // R7 reset during single access and during second word
    do_acc(bb + 24'h70, 2'd0, 1, 32'hEE, 1, 1, "R7");
    chk_reg(1, 16'h0001, "R7");
    cfg_write(1, 16'hABC8, 1);
    do_acc(bb + 24'h70, 2'd0, 0, 0, 1, -1, "R7");
    do_acc(bb + 24'h80, 2'd2, 1, 32'hCAFEF00D, 1, 2, "R7");
    chk_reg(1, 16'h0001, "R7");
    cfg_write(1, 16'hABC8, 1);
    do_acc(bb + 24'h80, 2'd2, 0, 0, 1, -1, "R7");

    // R8 reset during first word of a long
    do_acc(bb + 24'h90, 2'd2, 1, 32'h11223344, 1, 1, "R8");
    chk_reg(1, 16'h0001, "R8");
    cfg_write(1, 16'hABC8, 1);
    do_acc(bb + 24'h90, 2'd2, 0, 0, 1, -1, "R8");
    do_acc(bb + 24'hA1, 2'd1, 1, 32'h5566, 1, 1, "R8");
    cfg_write(1, 16'hABC8, 1);
    do_acc(bb + 24'hA0, 2'd2, 0, 0, 1, -1, "R8");

    // R12 reset while idle with a competing request
    cfg_write(0, 16'h0001, 1);
    do_acc(bb + 24'hB0, 2'd1, 1, 32'h4242, 1, 0, "R12");
    chk_reg(1, 16'h0001, "R12");
    chk_reg(0, 16'h0000, "R12");
    cfg_write(1, 16'hABC8, 1);
    do_acc(bb + 24'hB0, 2'd1, 0, 0, 1, -1, "R12");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [23:0] a;
      if (i % 64 == 0) cfg_write(0, {15'b0, 1'($urandom)}, 1);
      a = ($urandom % 8 != 0) ? {base_m, 11'($urandom)} : 24'($urandom);
      do_acc(a, 2'($urandom), 1'($urandom), $urandom, 1'($urandom), -1, "R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule